// File: doc/BRIEF.md
# Serial 1011 Pattern Spotter

This block watches a serial bit line and reports every place where the last four accepted bits read 1, 0, 1, 1. Matches may overlap, so the closing 1 of one match can open the next. The line is not accepted on every fast clock edge. An internal divider makes a slow tick, and one bit is taken on the fast edge where that tick is high. This lets a slowly toggled input be followed one bit per tick.

The recogniser is a five-state machine. Its detect pulse is combinational: it is high while the machine sits in the "matched 101" state and the line carries a 1, so it rises and falls with the input and not with a clock edge. The first tick that accepts such a pulse sets a sticky flag, which then stays set until reset. The current state is also brought out as a one-hot vector so it can be observed directly. The active-low reset acts at once, without waiting for any clock edge or tick, and it clears the state, the flag and the divider.

Top module: `pattern_spotter`

## Requirements
- R1: While `rst_n` is low, and immediately when it falls with no clock edge needed, `state_oh` is 5'b00001 (idle) and `seen_flag` is 0.
- R2: The state changes only on tick edges. After `rst_n` rises, the first tick is the (TICK_DIV+1)-th rising clock edge, and further ticks follow every 2*(TICK_DIV+1) edges. Between ticks, `state_oh` holds its value.
- R3: From idle, an accepted 1 moves to the "1" state and a 0 stays in idle. From the "1" state, a 1 stays and a 0 moves to the "10" state.
- R4: From the "10" state, a 1 moves to the "101" state and a 0 returns to idle. From the "101" state, a 1 moves to the full-match state and a 0 moves back to the "10" state.
- R5: From the full-match state, a 1 moves to the "1" state and a 0 moves to the "10" state.
- R6: `hit_pulse` is high exactly when the state is "101" and `serial_in` is 1. It follows `serial_in` combinationally, with no clock edge in between.
- R7: `seen_flag` is set by a tick that accepts a bit while `hit_pulse` is high. After that it stays at 1 through all later ticks, and only reset clears it.
- R8: The `state_oh` encoding, from bit 0 upward, is: idle=00001, "1"=00010, "10"=00100, "101"=01000, full match=10000. Exactly one bit is set at all times.
- R9: The accepted stream 1,0,1,0,1,1 gives exactly one hit, on its last bit. The stream 1,0,1,1,0,1,1 gives two hits, on the fourth bit and on the seventh bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| serial_in | input | 1 | Serial bit, accepted on tick edges |
| seen_flag | output | 1 | Sticky flag: a match has been seen since reset |
| hit_pulse | output | 1 | Raw combinational detect from the state and the input |
| state_oh | output | 5 | One-hot view of the current state |

## Verification
The bench builds the block with TICK_DIV=3, which gives one tick every eight fast clocks. At that rate a stream covering every transition arc, both overlap streams and a check that the flag persists all fit in a few hundred cycles.

The bench holds each bit for one full tick window. It checks the state halfway through the window to confirm that nothing moves before the tick. It reads `hit_pulse` before the tick, while the old state is still present. It drops reset between clock edges, so that the asynchronous clear is seen without any edge.

// File: rtl/spot_pkg.sv
package spot_pkg;
   localparam int unsigned NUM_STATES = 5;
   localparam int unsigned STATE_W    = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE   = 3'd0,
      ST_ONE    = 3'd1,
      ST_TEN    = 3'd2,
      ST_TENONE = 3'd3,
      ST_FULL   = 3'd4
   } spot_state_e;
endpackage

// File: rtl/spot_tick_gen.sv
module spot_tick_gen #(
   parameter int unsigned TICK_DIV = 33333333
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_en
);
   localparam int unsigned CW = $clog2(TICK_DIV + 1);
   localparam logic [CW-1:0] TERM = CW'(TICK_DIV);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("spot_tick_gen: TICK_DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (cnt_q == TERM) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // tick on the slow phase's rising transition
   assign tick_en = (cnt_q == TERM) && !phase_q;

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> !tick_en); // R2
endmodule

// File: rtl/spot_fsm.sv
module spot_fsm
   import spot_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_en,
   input  logic        bit_in,
   output spot_state_e state_q,
   output logic        hit
);
   spot_state_e nxt;

   always_comb begin
      nxt = ST_IDLE;
      hit = 1'b0;
      unique case (state_q)
         ST_IDLE:   nxt = bit_in ? ST_ONE    : ST_IDLE;
         ST_ONE:    nxt = bit_in ? ST_ONE    : ST_TEN;
         ST_TEN:    nxt = bit_in ? ST_TENONE : ST_IDLE;
         ST_TENONE: begin
            nxt = bit_in ? ST_FULL : ST_TEN;
            hit = bit_in;
         end
         ST_FULL:   nxt = bit_in ? ST_ONE    : ST_TEN;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= ST_IDLE;
      else if (tick_en) state_q <= nxt;
   end

   AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(state_q)); // R2
   AST_HIT_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && hit) |=> (state_q == ST_FULL)); // R4
   AST_FULL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && state_q == ST_FULL) |=> (state_q == ST_ONE || state_q == ST_TEN)); // R5
endmodule

// File: rtl/spot_flag.sv
module spot_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   output logic seen_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_q <= 1'b0;
      else if (set_en) seen_q <= 1'b1;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> seen_q); // R7
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> seen_q); // R7
endmodule

// File: rtl/pattern_spotter.sv
module pattern_spotter
   import spot_pkg::*;
#(
   parameter int unsigned TICK_DIV = 33333333
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  serial_in,
   output logic                  seen_flag,
   output logic                  hit_pulse,
   output logic [NUM_STATES-1:0] state_oh
);
   logic        tick_en;
   spot_state_e st;

   spot_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en)
   );

   spot_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .bit_in  (serial_in),
      .state_q (st),
      .hit     (hit_pulse)
   );

   spot_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (tick_en && hit_pulse),
      .seen_q (seen_flag)
   );

   generate
      for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
         assign state_oh[i] = (st == spot_state_e'(i));
      end
   endgenerate

   AST_ONE_HOT_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh) == 1); // R8
endmodule

// File: tb/pattern_spotter_tb_top.sv
module pattern_spotter_tb_top;
   localparam int unsigned DIV = 3;
   localparam int unsigned WIN = 2 * (DIV + 1);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       serial_in = 1'b0;
   logic       seen_flag;
   logic       hit_pulse;
   logic [4:0] state_oh;

   int n_checks = 0;
   int n_fail = 0;
   int exp_state = 0;
   bit exp_flag = 1'b0;
   int hits = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pattern_spotter #(.TICK_DIV(DIV)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .serial_in (serial_in),
      .seen_flag (seen_flag),
      .hit_pulse (hit_pulse),
      .state_oh  (state_oh)
   );

   function automatic int model_next(int s, bit b);
      case (s)
         0: return b ? 1 : 0;
         1: return b ? 1 : 2;
         2: return b ? 3 : 0;
         3: return b ? 4 : 2;
         default: return b ? 1 : 2;
      endcase
   endfunction

   function automatic string arc_tag(int s);
      if (s <= 1) return "R3";
      if (s <= 3) return "R4";
      return "R5";
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reset dropped between clock edges, checked before any edge
   task automatic do_reset();
      @(negedge clk);
      #5 rst_n = 1'b0;
      serial_in = 1'b0;
      #2;
      check(state_oh == 5'b00001, "R1 R8", "state_oh during reset", state_oh, 1);
      check(seen_flag == 1'b0, "R1", "seen_flag during reset", seen_flag, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_state = 0;
      exp_flag = 1'b0;
   endtask

   // one bit per tick window; starts and ends on a falling edge
   task automatic feed_bit(bit b);
      int src;
      bit exp_hit;
      src = exp_state;
      serial_in = b;
      #1;
      exp_hit = (src == 3) && b;
      check(hit_pulse == exp_hit, "R6", "hit_pulse before tick", hit_pulse, exp_hit);
      repeat (2) @(posedge clk);
      #5;
      check(state_oh == (5'b1 << src), "R2", "state held before tick", state_oh, 1 << src);
      repeat (WIN - 2) @(posedge clk);
      @(negedge clk);
      if (exp_hit) begin
         exp_flag = 1'b1;
         hits++;
      end
      exp_state = model_next(src, b);
      check(state_oh == (5'b1 << exp_state), arc_tag(src), "state after tick",
            state_oh, 1 << exp_state);
      check(seen_flag == exp_flag, "R7", "seen_flag after tick", seen_flag, exp_flag);
   endtask

   task automatic t_all_arcs();
      bit seq[16] = '{0,1,1,0,0,1,0,1,0,1,1,1,0,1,1,0};
      do_reset();
      foreach (seq[i]) feed_bit(seq[i]);
   endtask

   task automatic t_sticky();
      do_reset();
      feed_bit(1); feed_bit(0); feed_bit(1); feed_bit(1);
      for (int k = 0; k < 5; k++) feed_bit(0);
      check(seen_flag == 1'b1, "R7", "flag persists after zeros", seen_flag, 1);
      do_reset();
      check(seen_flag == 1'b0, "R7", "flag cleared by reset", seen_flag, 0);
   endtask

   task automatic t_wrong_bit();
      bit seq[6] = '{1,0,1,0,1,1};
      do_reset();
      hits = 0;
      foreach (seq[i]) feed_bit(seq[i]);
      check(hits == 1, "R9", "hits for 101011", hits, 1);
   endtask

   task automatic t_overlap();
      bit seq[7] = '{1,0,1,1,0,1,1};
      do_reset();
      hits = 0;
      foreach (seq[i]) feed_bit(seq[i]);
      check(hits == 2, "R9", "hits for 1011011", hits, 2);
   endtask

   task automatic t_comb_hit();
      do_reset();
      feed_bit(1); feed_bit(0); feed_bit(1);
      serial_in = 1'b0;
      #2;
      check(hit_pulse == 1'b0, "R6", "hit_pulse with input 0 in 101", hit_pulse, 0);
      serial_in = 1'b1;
      #2;
      check(hit_pulse == 1'b1, "R6", "hit_pulse follows input", hit_pulse, 1);
      serial_in = 1'b0;
      #2;
      check(hit_pulse == 1'b0, "R6", "hit_pulse drops with input", hit_pulse, 0);
   endtask

   initial begin
      t_all_arcs();
      t_sticky();
      t_wrong_bit();
      t_overlap();
      t_comb_hit();
      do_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule